// File: doc/BRIEF.md
# Self-Restarting Parallel-to-Serial Converter

This block turns a 7-bit parallel word into a serial bit stream. An 8-stage shift register is loaded with a zero marker in stage 0 and the data word in stages 1 to 7. It then shifts toward stage 7 and fills with ones from stage 0. The serial output is taken from stage 7.

No counter measures the word. When the marker zero has moved to stage 7, stages 0 to 6 all hold ones. That pattern is the completion condition. It raises the done output and forces a reload on the next clock, so back-to-back words stream without any help from outside. Each word takes eight cycles: seven data bits, then one gap cycle in which the marker is on the output.

An active-low start input forces a load on any clock. Holding it low keeps reloading the word, and pulsing it low in the middle of a word abandons that word and starts the next one. The reset input acts asynchronously when it falls and is released to the logic through a two-flop synchronizer.

Top module: `p2s_restart_ser`

## Requirements
- R1: While `rst_n` is low, stages 0..6 hold ones and stage 7 holds zero, so `sout` is 0 and `done` is 1. This takes effect at once, without waiting for a clock edge.
- R2: Reset release is synchronised. For the first two rising edges after `rst_n` rises the outputs keep their reset values (`sout` 0, `done` 1), and the first load happens on the third edge.
- R3: A load happens on a rising edge when `start_n` is low or `done` is high. The load puts 0 into stage 0 and `din[i]` into stage i+1 for i = 0..6. After the load, `sout` equals `din[6]`.
- R4: On any other edge, every stage takes the value of the stage below it and stage 0 takes a 1. After a load, `sout` therefore gives `din[6]`, `din[5]`, …, `din[0]` on consecutive cycles.
- R5: `done` is 1 exactly when stages 0..6 are all ones. This happens in the cycle after the seventh shift, and in that cycle `sout` is 0.
- R6: With `start_n` held high, words follow each other every 8 cycles: 7 data cycles with `done` low, then one gap cycle with `done` high. `done` is never high in two consecutive cycles.
- R7: `din` is sampled only on load edges. Changes to `din` during the shift cycles have no effect on `sout`.
- R8: A word whose `din[5:0]` are all ones does not end early. `done` stays low for all 7 data cycles.
- R9: `start_n` low on an edge reloads the register even in the middle of a word. The stream restarts from the new `din[6]`, and holding `start_n` low reloads on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases through a synchronizer |
| start_n | input | 1 | Active-low load request, sampled on each rising edge |
| din | input | 7 | Parallel data word; bit i goes to stage i+1 on a load |
| sout | output | 1 | Serial output, taken from stage 7 |
| done | output | 1 | High while stages 0..6 are all ones (word finished, reload pending) |

## Verification
The hardest case to reach is a word that, right after its load, already shows ones in stages 1 to 6. A detector that watches only those stages would end that word at once. The stream therefore includes the all-ones word and the word with only `din[6]` clear, and the scoreboard expects a full seven-bit burst for each before the gap.

An abort in the middle of a word can only be created by timing `start_n` against the shift position. A directed phase waits for a gap cycle, lets exactly two shifts pass, and then pulses `start_n` low. It then checks that the stream restarts from the new word's top bit.

// File: rtl/p2s_pkg.sv
`timescale 1ns/1ps
package p2s_pkg;

  // Control code of the universal shift register.
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,  // stage i <- stage i-1, stage 0 <- sin_r
    MODE_SHL  = 2'b10,  // stage i <- stage i+1, top stage <- sin_l
    MODE_LOAD = 2'b11   // parallel load
  } sr_mode_e;

endpackage

// File: rtl/p2s_rst_sync.sv
`timescale 1ns/1ps
module p2s_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[TOP];

endmodule

// File: rtl/p2s_ushift.sv
`timescale 1ns/1ps
module p2s_ushift
  import p2s_pkg::*;
#(
  parameter int unsigned      W       = 8,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sr_mode_e      mode,
  input  logic          sin_r,
  input  logic          sin_l,
  input  logic [W-1:0]  pdata,
  output logic [W-1:0]  q
);

  localparam int unsigned TOP = W - 1;

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         en;

  // Per-stage next-value selection.
  for (genvar i = 0; i < W; i++) begin : g_stage
    logic from_low;
    logic from_high;
    logic nxt;

    if (i == 0) begin : g_bottom
      assign from_low = sin_r;
    end else begin : g_mid_low
      assign from_low = q_r[i-1];
    end

    if (i == TOP) begin : g_top
      assign from_high = sin_l;
    end else begin : g_mid_high
      assign from_high = q_r[i+1];
    end

    always_comb begin
      unique case (mode)
        MODE_SHR:  nxt = from_low;
        MODE_SHL:  nxt = from_high;
        MODE_LOAD: nxt = pdata[i];
        default:   nxt = q_r[i];
      endcase
    end

    assign q_nxt[i] = nxt;
  end

  assign en = (mode != MODE_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST_VAL;
    end else if (en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

  // R3: a load edge leaves the sampled parallel word in the stages
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && mode == MODE_LOAD) |=> (q_r == $past(pdata)));

  // R4: a right shift moves every stage up by one and inserts sin_r
  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && mode == MODE_SHR) |=> (q_r == {$past(q_r[TOP-1:0]), $past(sin_r)}));

endmodule

// File: rtl/p2s_done_det.sv
`timescale 1ns/1ps
module p2s_done_det
  import p2s_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic          start_n,
  input  logic [W-1:0]  low_stages,
  output logic          done,
  output sr_mode_e      mode
);

  // Completion: the marker zero has left every watched stage.
  assign done = &low_stages;

  always_comb begin
    if (!start_n || done) begin
      mode = MODE_LOAD;
    end else begin
      mode = MODE_SHR;
    end
  end

endmodule

// File: rtl/p2s_restart_ser.sv
`timescale 1ns/1ps
module p2s_restart_ser
  import p2s_pkg::*;
#(
  parameter int unsigned DATA_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic [DATA_W-1:0] din,
  output logic              sout,
  output logic              done
);

  localparam int unsigned        REG_W     = DATA_W + 1;
  localparam int unsigned        OUT_IDX   = REG_W - 1;
  localparam logic [REG_W-1:0]   IDLE_PATT = {1'b0, {DATA_W{1'b1}}};

  logic             rst_core_n;
  sr_mode_e         mode;
  logic [REG_W-1:0] stages;
  logic             det;

  p2s_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  p2s_ushift #(
    .W       (REG_W),
    .RST_VAL (IDLE_PATT)
  ) u_shreg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .mode  (mode),
    .sin_r (1'b1),
    .sin_l (1'b0),
    .pdata ({din, 1'b0}),
    .q     (stages)
  );

  p2s_done_det #(
    .W (DATA_W)
  ) u_done_det (
    .start_n    (start_n),
    .low_stages (stages[DATA_W-1:0]),
    .done       (det),
    .mode       (mode)
  );

  assign sout = stages[OUT_IDX];
  assign done = det;

  // R5: the gap cycle always presents the marker zero
  p_gap_silent_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rst_core_n && done) |-> !sout);

  // R6: completion is followed by a reload, never by a second gap cycle
  p_gap_once_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rst_core_n && done) |=> !done);

  // R9: a start request restarts the word from its top data bit
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rst_core_n && !start_n) |=> (!done && sout == $past(din[DATA_W-1])));

endmodule

// File: tb/p2s_restart_ser_bench.sv
`timescale 1ns/1ps
module p2s_restart_ser_bench;

  localparam int DW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_n;
  logic [DW-1:0] din;
  logic          sout;
  logic          done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  b;
    logic  d;
    string req;
  } item_t;

  item_t sb[$];

  always #2 clk = ~clk;

  p2s_restart_ser #(.DATA_W(DW)) u_p2s_restart_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .din     (din),
    .sout    (sout),
    .done    (done)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick(input int i);
    case (i)
      0: return 7'h3F;   // R8: stages 1..6 all ones after load
      1: return 7'h7F;   // R8
      2: return 7'h00;
      3: return 7'h01;
      4: return 7'h40;
      5: return 7'h55;
      6: return 7'h2A;
      default: return 7'((i * 37 + 11) % 128);
    endcase
  endfunction

  // Driver: wait for a gap cycle, present the word, queue expected bits,
  // then scramble din during the shift cycles (R7).
  task automatic send_word(input logic [DW-1:0] w, input int idx);
    item_t it;
    do @(negedge clk); while (done !== 1'b1);
    din = w;
    for (int k = DW - 1; k >= 0; k--) begin
      it.b   = w[k];
      it.d   = 1'b0;
      it.req = (w[5:0] == 6'h3F) ? "R8" : ((idx % 2 == 1) ? "R7" : "R4");
      sb.push_back(it);
    end
    it.b   = 1'b0;
    it.d   = 1'b1;
    it.req = (idx % 2 == 1) ? "R6" : "R5";
    sb.push_back(it);
    for (int k = 0; k < DW; k++) begin
      @(negedge clk);
      din = ~w ^ 7'(k * 3);
    end
  endtask

  // Monitor: compare each cycle's outputs against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        chk(it.req, "sout", {7'd0, sout}, {7'd0, it.b});
        chk(it.req, "done", {7'd0, done}, {7'd0, it.d});
      end
    end
  end

  // Watchdog
  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    rst_n   = 1'b0;
    start_n = 1'b1;
    din     = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "sout in reset", {7'd0, sout}, 8'd0);
    chk("R1", "done in reset", {7'd0, done}, 8'd1);

    // R2: two edges pass at reset values after release
    @(negedge clk);
    rst_n = 1'b1;
    din   = 7'h7F;
    @(posedge clk); #1;
    chk("R2", "done edge 1", {7'd0, done}, 8'd1);
    chk("R2", "sout edge 1", {7'd0, sout}, 8'd0);
    @(posedge clk); #1;
    chk("R2", "done edge 2", {7'd0, done}, 8'd1);
    chk("R2", "sout edge 2", {7'd0, sout}, 8'd0);

    // Scoreboard stream: back-to-back words, gap included
    for (int i = 0; i < 20; i++) send_word(pick(i), i);
    while (sb.size() != 0) @(posedge clk);

    // Directed phase: R9 repeated loads with start_n held low
    do @(negedge clk); while (done !== 1'b1);
    start_n = 1'b0;
    din     = 7'h40;
    @(negedge clk);
    chk("R9", "held load 1", {7'd0, sout}, 8'd1);
    chk("R9", "held load 1 done", {7'd0, done}, 8'd0);
    din = 7'h00;
    @(negedge clk);
    chk("R9", "held load 2", {7'd0, sout}, 8'd0);
    din = 7'h25;
    @(negedge clk);
    chk("R9", "held load 3", {7'd0, sout}, 8'd0);
    start_n = 1'b1;
    din     = 7'h5A;
    w = 7'h25;
    for (int k = DW - 2; k >= 0; k--) begin
      @(negedge clk);
      chk("R9", "stream after held start", {7'd0, sout}, {7'd0, w[k]});
    end
    @(negedge clk);
    chk("R5", "gap done", {7'd0, done}, 8'd1);
    chk("R5", "gap sout", {7'd0, sout}, 8'd0);

    // R3 load via completion, then R9 abort after two shifts
    w   = 7'h6C;
    din = w;
    @(negedge clk);
    chk("R3", "load top bit", {7'd0, sout}, {7'd0, w[6]});
    din = 7'h00;
    @(negedge clk);
    chk("R4", "shift 1", {7'd0, sout}, {7'd0, w[5]});
    @(negedge clk);
    chk("R4", "shift 2", {7'd0, sout}, {7'd0, w[4]});
    start_n = 1'b0;
    w   = 7'h13;
    din = w;
    @(negedge clk);
    chk("R9", "abort reload", {7'd0, sout}, {7'd0, w[6]});
    chk("R9", "abort done", {7'd0, done}, 8'd0);
    start_n = 1'b1;
    din     = 7'h7F;
    for (int k = DW - 2; k >= 0; k--) begin
      @(negedge clk);
      chk("R9", "stream after abort", {7'd0, sout}, {7'd0, w[k]});
    end
    @(negedge clk);
    chk("R6", "gap after abort", {7'd0, done}, 8'd1);

    // R1: asynchronous reset in the middle of a word
    @(negedge clk);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset sout", {7'd0, sout}, 8'd0);
    chk("R1", "async reset done", {7'd0, done}, 8'd1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule